// File: doc/BRIEF.md
# Converter Serial Port Device Model

This block is a synthesizable stand-in for the digital side of a 12-bit successive-approximation converter. It sits on the far end of a host controller's serial link during verification. It watches a conversion-request line and times each conversion with an internal counter. It produces a 12-bit result from two digital sample inputs that stand in for the analog channels. It then serves that result on a serial data output while it shifts in a 6-bit setup word.

Every line coming from the host (request, serial clock, serial data in) is treated as asynchronous. Each one is resynchronised into the fast internal clock, and the block acts on the edges it detects after synchronisation. The setup word received during one read-out governs the conversion that starts after it. Holding the request line high past the end of a conversion puts the model into its power-down state.

Top module: `sar_port_model`

## Requirements
- R1: A rising edge on `conv_req` while idle starts a conversion, captures `chan_a`/`chan_b` and the current setup at that edge, and loads the result into the output latch after `CONV_CYCLES` internal clocks.
- R2: A rising edge on `conv_req` during a conversion is ignored: the running conversion neither restarts nor resamples its inputs.
- R3: `sdo_oe` is high only while `conv_req` is low, no conversion is running and the model is not asleep.
- R4: Once `sdo_oe` is high, `sdo` carries result bit 11; each falling `sck` edge moves to the next lower bit, down to bit 0.
- R5: After `conv_req` falls, only the first six rising `sck` edges with `sdo_oe` high sample `sdi`. Bit 1 selects single-ended (1) or differential (0). Bit 2 is odd/sign. Bit 5 selects unipolar (1) or bipolar (0). Bits 3, 4 and 6 and all later edges are ignored.
- R6: Channel selection: single-ended with odd/sign 0 converts `chan_a` against 0, and with odd/sign 1 converts `chan_b` against 0. Differential with odd/sign 0 converts `chan_a` minus `chan_b`, and with odd/sign 1 converts `chan_b` minus `chan_a`.
- R7: Unipolar output is the difference as straight binary, with negative values clamped to 0. Bipolar output is the difference in 12-bit two's complement, saturated to 0x7FF and 0x800.
- R8: A setup word takes effect on the first conversion started after its sixth bit. After reset the setup is single-ended, `chan_a`, unipolar.
- R9: If `conv_req` is still high when a conversion ends, `asleep` goes high and `sdo_oe` stays low. Both return to normal when `conv_req` falls.
- R10: A rising edge of `conv_req` fewer than `ACQ_CYCLES` internal clocks after the sixth setup bit sets `proto_err`, which stays set until reset.
- R11: After reset, `asleep` and `proto_err` are low, the output latch holds zero, and `sdo_oe` is high while `conv_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_req | input | 1 | Conversion request line (asynchronous) |
| sck | input | 1 | Serial clock from the host (asynchronous) |
| sdi | input | 1 | Serial setup data from the host |
| chan_a | input | DATA_W | Sample value standing in for the first channel |
| chan_b | input | DATA_W | Sample value standing in for the second channel |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Drive enable for `sdo` (low = high impedance) |
| asleep | output | 1 | Power-down state flag |
| proto_err | output | 1 | Sticky flag for a request issued too early |

## Verification
Each host edge reaches the logic after the two synchroniser stages plus the edge register, so roughly three internal clocks after the pin moves. A result appears `CONV_CYCLES` clocks after the accepted request edge. The bench holds every `sck` phase for eight clocks and reads `sdo` at the start of each bit period, well after the preceding falling edge has taken effect. Flag and enable checks are placed at least ten clocks past the edge that should cause them. The restart check is sampled in the window after the genuine end of conversion and before a restarted one could finish.

// File: rtl/sar_port_pkg.sv
// Shared types for the converter serial port model.
package sar_port_pkg;

    // Decoded conversion setup: input routing and output encoding.
    typedef struct packed {
        logic single_ended;  // 1: channel against ground, 0: channel pair
        logic odd_sign;      // picks channel / pair polarity
        logic unipolar;      // 1: straight binary, 0: two's complement
    } sp_cfg_t;

    localparam sp_cfg_t SP_CFG_RESET = '{single_ended: 1'b1, odd_sign: 1'b0, unipolar: 1'b1};

endpackage

// File: rtl/sp_sync.sv
// Resynchronises one asynchronous line into clk and flags its edges.
// Assumes STAGES >= 2; line reads as low while in reset.
module sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the line through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/sp_conv_ctrl.sv
// Conversion timer, power-down state and acquisition-window checker.
// Assumes request edges arrive already synchronised to clk.
module sp_conv_ctrl #(
    parameter int CONV_CYCLES = 260,
    parameter int ACQ_CYCLES  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_level,
    input  logic req_rise,
    input  logic req_fall,
    input  logic setup_done,
    output logic go,
    output logic busy,
    output logic done,
    output logic asleep,
    output logic proto_err
);
    localparam int TW = $clog2(CONV_CYCLES + 1);
    localparam int AW = $clog2(ACQ_CYCLES + 1);

    logic [TW-1:0] timer;
    logic [AW-1:0] acq_left;

    assign go   = req_rise & ~busy;
    assign done = busy & (timer == '0);

    // Run the fixed-length conversion; new requests while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            timer <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            timer <= TW'(CONV_CYCLES - 1);
        end else if (busy) begin
            if (timer == '0) busy <= 1'b0;
            else             timer <= timer - 1'b1;
        end
    end

    // Enter power-down when the request is still high at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 asleep <= 1'b0;
        else if (done && req_level) asleep <= 1'b1;
        else if (req_fall)          asleep <= 1'b0;
    end

    // Count down the acquisition window opened by the last setup bit.
    always_ff @(posedge clk) begin
        if (!rst_n)             acq_left <= '0;
        else if (setup_done)    acq_left <= AW'(ACQ_CYCLES);
        else if (acq_left != '0) acq_left <= acq_left - 1'b1;
    end

    // Latch a protocol error on a request inside the acquisition window.
    always_ff @(posedge clk) begin
        if (!rst_n)                          proto_err <= 1'b0;
        else if (req_rise && acq_left != '0) proto_err <= 1'b1;
    end

    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && timer != '0) |=> (busy && timer == $past(timer) - 1'b1));

    assert_sleep_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(busy && req_level));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: rtl/sp_result.sv
// Forms the converted word from captured samples and setup (combinational).
// Assumes samples are unsigned codes of DATA_W bits.
module sp_result
    import sar_port_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    input  sp_cfg_t           cfg,
    output logic [DATA_W-1:0] word
);
    localparam int SW   = DATA_W + 2;
    localparam int MAXI = 2 ** (DATA_W - 1) - 1;
    localparam logic signed [SW-1:0] MAXV = SW'(MAXI);
    localparam logic signed [SW-1:0] MINV = SW'(-MAXI - 1);

    logic signed [SW-1:0] pos, neg, diff;

    // Route the selected inputs and take their difference.
    always_comb begin
        pos = $signed({2'b00, (cfg.odd_sign ? samp_b : samp_a)});
        if (cfg.single_ended) neg = '0;
        else                  neg = $signed({2'b00, (cfg.odd_sign ? samp_a : samp_b)});
        diff = pos - neg;
    end

    // Encode: clamp at zero for unipolar, saturate for bipolar.
    always_comb begin
        if (cfg.unipolar) begin
            word = diff[SW-1] ? '0 : diff[DATA_W-1:0];
        end else if (diff > MAXV) begin
            word = MAXV[DATA_W-1:0];
        end else if (diff < MINV) begin
            word = MINV[DATA_W-1:0];
        end else begin
            word = diff[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/sp_shifter.sv
// Output latch / serialiser and setup-word receiver.
// Assumes sck edges are synchronised pulses; shifting only while enabled.
module sp_shifter #(
    parameter int DATA_W   = 12,
    parameter int CFG_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   load_word,
    input  logic                en,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                din,
    input  logic                frame_start,
    output logic                dout,
    output logic                setup_done,
    output logic [CFG_BITS-1:0] setup_word
);
    localparam int CW = $clog2(CFG_BITS + 1);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic              take;

    assign take = sck_rise && en && (cnt < CW'(CFG_BITS));

    // Load a finished result or move to the next bit on a falling sck.
    always_ff @(posedge clk) begin
        if (!rst_n)              shreg <= '0;
        else if (load)           shreg <= load_word;
        else if (sck_fall && en) shreg <= {shreg[DATA_W-2:0], 1'b0};
    end

    // Collect the first CFG_BITS data-in bits of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            setup_word <= '0;
        end else if (frame_start) begin
            cnt <= '0;
        end else if (take) begin
            cnt        <= cnt + 1'b1;
            setup_word <= {setup_word[CFG_BITS-2:0], din};
        end
    end

    // Flag the cycle after the last setup bit lands.
    always_ff @(posedge clk) begin
        if (!rst_n) setup_done <= 1'b0;
        else        setup_done <= take && (cnt == CW'(CFG_BITS - 1));
    end

    assign dout = shreg[DATA_W-1];

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && en && !load) |=> (dout == $past(shreg[DATA_W-2])));

    assert_setup_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |-> (cnt == CW'(CFG_BITS)));
endmodule

// File: rtl/sar_port_model.sv
// Top: device-side model of a converter serial port.
// Assumes host lines are asynchronous to clk and far slower than it.
module sar_port_model
    import sar_port_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CFG_BITS    = 6,
    parameter int CONV_CYCLES = 260,
    parameter int ACQ_CYCLES  = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_req,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] chan_a,
    input  logic [DATA_W-1:0] chan_b,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              asleep,
    output logic              proto_err
);
    localparam int POS_SE  = CFG_BITS - 1;
    localparam int POS_OS  = CFG_BITS - 2;
    localparam int POS_UNI = CFG_BITS - 5;

    logic req_lvl, req_rise, req_fall;
    logic sck_lvl_unused, sck_rise, sck_fall;
    logic sdi_lvl, sdi_rise_unused, sdi_fall_unused;
    logic go, busy, done, setup_done;
    logic [CFG_BITS-1:0] setup_word;
    logic                setup_word_unused;
    logic [DATA_W-1:0]   cap_a, cap_b, result;
    sp_cfg_t             cfg_q, conv_cfg;

    sp_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .async_in(conv_req),
        .level(req_lvl), .rise(req_rise), .fall(req_fall));
    sp_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .async_in(sck),
        .level(sck_lvl_unused), .rise(sck_rise), .fall(sck_fall));
    sp_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .async_in(sdi),
        .level(sdi_lvl), .rise(sdi_rise_unused), .fall(sdi_fall_unused));

    sp_conv_ctrl #(.CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_level(req_lvl), .req_rise(req_rise),
        .req_fall(req_fall), .setup_done(setup_done), .go(go), .busy(busy),
        .done(done), .asleep(asleep), .proto_err(proto_err));

    sp_result #(.DATA_W(DATA_W)) u_result (
        .samp_a(cap_a), .samp_b(cap_b), .cfg(conv_cfg), .word(result));

    sp_shifter #(.DATA_W(DATA_W), .CFG_BITS(CFG_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(done), .load_word(result),
        .en(sdo_oe), .sck_rise(sck_rise), .sck_fall(sck_fall), .din(sdi_lvl),
        .frame_start(req_fall), .dout(sdo), .setup_done(setup_done),
        .setup_word(setup_word));

    assign setup_word_unused = ^setup_word;
    assign sdo_oe = ~req_lvl & ~busy & ~asleep;

    // Hold the setup that the next accepted conversion will use.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= SP_CFG_RESET;
        else if (setup_done) begin
            cfg_q.single_ended <= setup_word[POS_SE];
            cfg_q.odd_sign     <= setup_word[POS_OS];
            cfg_q.unipolar     <= setup_word[POS_UNI];
        end
    end

    // Sample the channels and freeze the setup at the accepted request edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            conv_cfg <= SP_CFG_RESET;
        end else if (go) begin
            cap_a    <= chan_a;
            cap_b    <= chan_b;
            conv_cfg <= cfg_q;
        end
    end

    assert_setup_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(conv_cfg));

    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !sdo_oe);

    assert_quiet_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !sdo_oe);
endmodule

// File: tb/sar_port_model_tb.sv
`timescale 1ns/1ps
module sar_port_model_tb;
    localparam int CONV = 260;
    localparam int ACQ  = 48;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_req = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [11:0] chan_a = '0, chan_b = '0;
    logic sdo, sdo_oe, asleep, proto_err;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic c_se = 1'b1, c_os = 1'b0, c_uni = 1'b1;

    always #2.5 clk = ~clk;

    sar_port_model u_dut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .sck(sck), .sdi(sdi),
        .chan_a(chan_a), .chan_b(chan_b), .sdo(sdo), .sdo_oe(sdo_oe),
        .asleep(asleep), .proto_err(proto_err));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] model(input logic [11:0] a, input logic [11:0] b,
                                          input logic se, input logic os, input logic uni);
        int p, n, d;
        p = os ? int'(b) : int'(a);
        n = se ? 0 : (os ? int'(a) : int'(b));
        d = p - n;
        if (uni) return (d < 0) ? 12'h000 : 12'(d);
        if (d > 2047) return 12'h7FF;
        if (d < -2048) return 12'h800;
        return 12'(d);
    endfunction

    // Full 12-bit read-out while sending a setup word (MSB first).
    task automatic frame(input logic [5:0] w, output logic [11:0] got);
        for (int i = 0; i < 12; i++) begin
            got[11-i] = sdo;
            sdi = (i < 6) ? w[5-i] : 1'($urandom);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
            tick(HALF);
        end
    endtask

    // mode 0: normal, 1: second request mid-conversion, 2: held high into sleep
    task automatic round(input logic [11:0] a, input logic [11:0] b,
                         input logic [5:0] w, input int mode, input string tag);
        logic [11:0] exp, got;
        exp = model(a, b, c_se, c_os, c_uni);
        chan_a = a; chan_b = b;
        conv_req = 1'b1;
        if (mode == 2) begin
            tick(CONV + 20);
            chk("R9 asleep after held request", 32'(asleep), 32'd1);
            chk("R9 output off in sleep", 32'(sdo_oe), 32'd0);
            conv_req = 1'b0;
            tick(10);
            chk("R9 wake on low", 32'(asleep), 32'd0);
        end else begin
            tick(4);
            conv_req = 1'b0;
            tick(50);
            chk("R3 output off while converting", 32'(sdo_oe), 32'd0);
            if (mode == 1) begin
                tick(50);
                chan_a = ~a; chan_b = ~b;
                conv_req = 1'b1;
                tick(4);
                conv_req = 1'b0;
                tick(170);
                chk("R2 late request ignored, done on time", 32'(sdo_oe), 32'd1);
            end else begin
                tick(CONV);
            end
        end
        chk("R3 output on when idle and low", 32'(sdo_oe), 32'd1);
        frame(w, got);
        chk(tag, 32'(got), 32'(exp));
        c_se = w[5]; c_os = w[4]; c_uni = w[1];
        tick(ACQ + 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        tick(5);
        rst_n = 1'b1;
        tick(6);
        chk("R11 reset sleep", 32'(asleep), 32'd0);
        chk("R11 reset error", 32'(proto_err), 32'd0);
        chk("R11 reset enable", 32'(sdo_oe), 32'd1);
        chk("R11 reset latch", 32'(sdo), 32'd0);

        round(12'h123, 12'h456, 6'b001101, 0, "R8 default single-ended chan_a unipolar");
        round(12'hFFF, 12'h000, 6'b011101, 0, "R7 bipolar positive saturation");
        round(12'hFFF, 12'h000, 6'b000010, 0, "R7 bipolar negative saturation R6");
        round(12'd100, 12'd200, 6'b110010, 0, "R7 unipolar clamp to zero");
        round(12'h007, 12'hABC, 6'b100000, 0, "R6 single-ended chan_b");
        round(12'd1000, 12'hFFF, 6'b000010, 0, "R7 single-ended bipolar in range");
        round(12'h800, 12'h7F0, 6'b110011, 1, "R2 result from first request R1");
        round(12'h9A5, 12'h100, 6'b000000, 2, "R9 result after sleep R5");
        for (int k = 0; k < 20; k++)
            round(12'($urandom), 12'($urandom), 6'($urandom), 0, "R1 R4 R5 R6 R7 R8 random");
        chk("R10 no error with legal spacing", 32'(proto_err), 32'd0);

        chan_a = 12'h055;
        conv_req = 1'b1; tick(4); conv_req = 1'b0;
        tick(CONV + 10);
        for (int i = 0; i < 6; i++) begin
            sdi = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        tick(4);
        conv_req = 1'b1;
        tick(10);
        chk("R10 early request flagged", 32'(proto_err), 32'd1);
        conv_req = 1'b0;
        tick(CONV + 20);
        chk("R10 flag stays set", 32'(proto_err), 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule